// File: doc/BRIEF.md
# Keyed Watchdog Timer with Power-of-Two Scaler

This block is a watchdog timer placed on a simple 32-bit register bus. It is clocked by the system clock and advances on a slow tick enable of about 31.25 kHz. A free-running count is shifted right by a programmable 4-bit scale. The low 16 bits of the shifted value are compared against a 16-bit threshold. When the threshold is met, the block latches an interrupt-pending flag. It can also drive a one-cycle reset request toward the chip's reset logic.

Software must open a one-shot lock before each register write. The lock is opened by writing a key word to the key register. Any other write closes it again, whether or not that write was accepted. Software restarts the count by writing an exact magic word to the feed register. The count runs in one of two modes. In the first it counts on every tick. In the second it counts only while the `core_awake` input is high. With both mode bits cleared, the count is frozen.

Top module: `wdt_core`

## Requirements
- R1: A write to any register other than the key register (offset 0x1C) takes effect only when the previous write on the bus was the key word 0x0051F15E to offset 0x1C. Reading offset 0x1C returns 1 in bit 0 while the lock is open and 0 while it is closed.
- R2: Any write to an offset other than 0x1C closes the lock, whether or not it was accepted. A write of any other value to 0x1C also closes the lock.
- R3: An accepted write of 0x0D09F00D to the feed offset 0x18 clears the count to zero. An accepted write of any other value there leaves the count unchanged, but it still closes the lock.
- R4: The configuration register is at offset 0x00, with these fields: scale in bits [3:0], reset enable in bit 8, clear-on-match in bit 9, always-count in bit 12, count-while-awake in bit 13, and pending in bit 28. The count rises by one on each tick when bit 12 is set, or when bit 13 is set and `core_awake` is high. With bits 12 and 13 both clear, the count holds.
- R5: Offset 0x10 reads the low 16 bits of the count shifted right by the scale field.
- R6: The compare register at offset 0x20 stores bits [15:0] of a write. Bits [31:16] read back as zero.
- R7: The pending flag (bit 28, also driven on `irq`) sets in any cycle in which the scaled value is greater than or equal to the compare value. It stays set until an accepted configuration write with bit 28 clear, and only if no match occurs in that same cycle.
- R8: While the clear-on-match bit is set, a match clears the count to zero in place of incrementing it.
- R9: `wdog_rst` is high for exactly one cycle: the first cycle in which the pending flag reads 1 after having read 0, provided reset enable was set.
- R10: After reset the configuration, count and pending flag are zero, the compare value is 0xFFFF, and the lock is closed.
- R11: An accepted write to offset 0x08 loads the count. Reading offset 0x08 returns the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base enable, one cycle wide |
| core_awake | input | 1 | High while the core is running |
| req_write | input | 1 | Bus write strobe for this cycle |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for `req_addr`, combinational |
| irq | output | 1 | Interrupt-pending flag |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
The stimulus first exercises the lock with unlocked writes, locked writes, wrong key words and writes that follow a non-key write. This separates a lock that stays open from one that never opens. The count is then run in always-count and awake-only modes, with `core_awake` toggled. This shows whether the mode gating and the tick enable are respected. A preloaded count under a non-zero scale shows whether the shift is applied before the compare. Feeds with the magic word and with a near-miss value are also applied. A run with clear-on-match set shows whether a match wraps the count or lets it climb past the threshold. Throughout the run, a behavioural model predicts `irq`, `wdog_rst` and the read data on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SCALE_W = 4;

  localparam int OFF_CFG  = 'h00;
  localparam int OFF_CNT  = 'h08;
  localparam int OFF_SCL  = 'h10;
  localparam int OFF_FEED = 'h18;
  localparam int OFF_KEY  = 'h1C;
  localparam int OFF_CMP  = 'h20;

  localparam logic [31:0] KEY_WORD  = 32'h0051_F15E;
  localparam logic [31:0] FEED_WORD = 32'h0D09_F00D;

  localparam int B_RST_EN  = 8;
  localparam int B_ZERO    = 9;
  localparam int B_ALWAYS  = 12;
  localparam int B_AWAKE   = 13;
  localparam int B_PEND    = 28;

  typedef struct packed {
    logic               en_awake;
    logic               en_always;
    logic               zero_cmp;
    logic               rst_en;
    logic [SCALE_W-1:0] scale;
  } cfg_t;

  // Count shifted down by the scale, full width; caller truncates.
  function automatic logic [63:0] shift_down(input logic [63:0] c,
                                             input logic [SCALE_W-1:0] s);
    return c >> s;
  endfunction

  // Pack the configuration fields and pending flag into a read word.
  function automatic logic [31:0] cfg_word(input cfg_t c, input logic pend);
    logic [31:0] w;
    w = '0;
    w[SCALE_W-1:0] = c.scale;
    w[B_RST_EN]    = c.rst_en;
    w[B_ZERO]      = c.zero_cmp;
    w[B_ALWAYS]    = c.en_always;
    w[B_AWAKE]     = c.en_awake;
    w[B_PEND]      = pend;
    return w;
  endfunction

  // Unpack a write word into configuration fields.
  function automatic cfg_t cfg_fields(input logic [31:0] w);
    cfg_t c;
    c.scale     = w[SCALE_W-1:0];
    c.rst_en    = w[B_RST_EN];
    c.zero_cmp  = w[B_ZERO];
    c.en_always = w[B_ALWAYS];
    c.en_awake  = w[B_AWAKE];
    return c;
  endfunction

endpackage

// File: rtl/wdt_keylock.sv
module wdt_keylock #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              unlocked,
  output logic              wr_ok
);
  import wdt_pkg::*;

  logic is_key_addr;
  logic key_match;
  logic unl_q;

  assign is_key_addr = (req_addr == ADDR_W'(OFF_KEY));
  assign key_match   = is_key_addr && (req_wdata == KEY_WORD);

  // Every write re-arms or drops the lock; only a correct key re-arms it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
    end else if (req_write) begin
      unl_q <= key_match;
    end
  end

  assign unlocked = unl_q;
  assign wr_ok    = req_write && unl_q && !is_key_addr;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic               clr,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               zero_on_hit,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CMP_W-1:0]   cmp,
  output logic [CNT_W-1:0]   cnt,
  output logic [CMP_W-1:0]   scaled,
  output logic               hit
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [63:0]      shifted;

  assign shifted = shift_down(64'(cnt_q), scale);
  assign scaled  = shifted[CMP_W-1:0];
  assign hit     = (scaled >= cmp);

  // Priority: feed clear, bus load, clear-on-match, tick increment.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (hit && zero_on_hit) begin
      cnt_q <= '0;
    end else if (tick && run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  wdt_pkg::cfg_t    cfg_in,
  input  logic             pend_in,
  input  logic             cmp_wr,
  input  logic [CMP_W-1:0] cmp_in,
  input  logic             hit,
  output wdt_pkg::cfg_t    cfg_q,
  output logic             pend_q,
  output logic [CMP_W-1:0] cmp_q,
  output logic             rst_pulse
);
  import wdt_pkg::*;

  logic pend_n;

  // A match in the same cycle overrides a software clear.
  assign pend_n = (cfg_wr ? pend_in : pend_q) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      pend_q    <= 1'b0;
      cmp_q     <= '1;
      rst_pulse <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_in;
      if (cmp_wr) cmp_q <= cmp_in;
      pend_q    <= pend_n;
      rst_pulse <= !pend_q && pend_n && cfg_q.rst_en;
    end
  end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              core_awake,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              irq,
  output logic              wdog_rst
);
  import wdt_pkg::*;

  logic             unlocked;
  logic             wr_ok;
  logic             sel_cfg, sel_cnt, sel_scl, sel_feed, sel_key, sel_cmp;
  logic             cfg_wr, cmp_wr, cnt_wr, feed_ok;
  cfg_t             cfg_q;
  logic             pend_q;
  logic [CMP_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_val;
  logic [CMP_W-1:0] scaled;
  logic             hit;
  logic             run;
  logic             clr_hit;

  assign sel_cfg  = (req_addr == ADDR_W'(OFF_CFG));
  assign sel_cnt  = (req_addr == ADDR_W'(OFF_CNT));
  assign sel_scl  = (req_addr == ADDR_W'(OFF_SCL));
  assign sel_feed = (req_addr == ADDR_W'(OFF_FEED));
  assign sel_key  = (req_addr == ADDR_W'(OFF_KEY));
  assign sel_cmp  = (req_addr == ADDR_W'(OFF_CMP));

  wdt_keylock #(.ADDR_W(ADDR_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .unlocked  (unlocked),
    .wr_ok     (wr_ok)
  );

  assign cfg_wr  = wr_ok && sel_cfg;
  assign cmp_wr  = wr_ok && sel_cmp;
  assign cnt_wr  = wr_ok && sel_cnt;
  assign feed_ok = wr_ok && sel_feed && (req_wdata == FEED_WORD);

  wdt_ctrl #(.CMP_W(CMP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_in    (cfg_fields(req_wdata)),
    .pend_in   (req_wdata[B_PEND]),
    .cmp_wr    (cmp_wr),
    .cmp_in    (req_wdata[CMP_W-1:0]),
    .hit       (hit),
    .cfg_q     (cfg_q),
    .pend_q    (pend_q),
    .cmp_q     (cmp_q),
    .rst_pulse (wdog_rst)
  );

  assign run     = cfg_q.en_always || (cfg_q.en_awake && core_awake);
  assign clr_hit = hit && cfg_q.zero_cmp;

  wdt_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run         (run),
    .clr         (feed_ok),
    .load        (cnt_wr),
    .load_val    (req_wdata[CNT_W-1:0]),
    .zero_on_hit (cfg_q.zero_cmp),
    .scale       (cfg_q.scale),
    .cmp         (cmp_q),
    .cnt         (cnt_val),
    .scaled      (scaled),
    .hit         (hit)
  );

  always_comb begin
    rsp_rdata = '0;
    if (sel_cfg)  rsp_rdata = cfg_word(cfg_q, pend_q);
    if (sel_cnt)  rsp_rdata = 32'(cnt_val);
    if (sel_scl)  rsp_rdata = 32'(scaled);
    if (sel_key)  rsp_rdata = 32'(unlocked);
    if (sel_cmp)  rsp_rdata = 32'(cmp_q);
  end

  assign irq = pend_q;

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rsp_rdata,
  input logic              unlocked,
  input logic              wr_ok,
  input logic              cfg_wr,
  input logic              clr_hit,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              irq,
  input logic              wdog_rst
);
  import wdt_pkg::*;

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && req_addr == ADDR_W'(OFF_KEY) && req_wdata == KEY_WORD) |=> unlocked); // R1

  AST_LOCK_RECLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !unlocked); // R2

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !req_write && !clr_hit) |=> $stable(cnt_val)); // R4

  AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == ADDR_W'(OFF_CMP)) |-> ((rsp_rdata >> CMP_W) == 32'd0)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_wr) |=> irq); // R7

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst); // R9

  AST_RST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> (irq && !$past(irq))); // R9

endmodule

bind wdt_core wdt_core_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_rdata (rsp_rdata),
  .unlocked  (unlocked),
  .wr_ok     (wr_ok),
  .cfg_wr    (cfg_wr),
  .clr_hit   (clr_hit),
  .cnt_val   (cnt_val),
  .irq       (irq),
  .wdog_rst  (wdog_rst)
);

// File: tb/wdt_core_tb.sv
`timescale 1ns/1ps
module wdt_core_tb;
  localparam int AW = 6;
  localparam logic [31:0] KEYV = 32'h0051F15E;
  localparam logic [31:0] FOOD = 32'h0D09F00D;
  localparam int A_CFG = 'h00, A_CNT = 'h08, A_SCL = 'h10, A_FEED = 'h18, A_KEY = 'h1C, A_CMP = 'h20;

  logic clk = 0, rst_n = 0, tick = 0, core_awake = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic irq, wdog_rst;
  logic tick_en = 0;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_core u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .core_awake(core_awake),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .irq(irq), .wdog_rst(wdog_rst));

  always @(negedge clk) tick = tick_en;

  // Behavioural reference state
  longint m_cnt = 0;
  int m_scale = 0, m_cmp = 'hFFFF;
  bit m_rsten = 0, m_zc = 0, m_ena = 0, m_enw = 0, m_pend = 0, m_unl = 0, m_rst = 0;

  function automatic logic [31:0] exp_read(int a);
    case (a)
      A_CFG:  return (32'(m_pend) << 28) | (32'(m_enw) << 13) | (32'(m_ena) << 12) |
                     (32'(m_zc) << 9) | (32'(m_rsten) << 8) | 32'(m_scale);
      A_CNT:  return 32'(m_cnt);
      A_SCL:  return 32'((m_cnt / (64'd1 << m_scale)) % 65536);
      A_KEY:  return 32'(m_unl);
      A_CMP:  return 32'(m_cmp);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      A_CFG: return "R4"; A_CNT: return "R11"; A_SCL: return "R5";
      A_FEED: return "R3"; A_KEY: return "R2"; default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_scale = 0; m_cmp = 'hFFFF; m_rsten = 0; m_zc = 0;
      m_ena = 0; m_enw = 0; m_pend = 0; m_unl = 0; m_rst = 0;
    end else begin
      longint sc;
      bit hit, acc, np;
      int a;
      a = int'(req_addr);
      sc = (m_cnt / (64'd1 << m_scale)) % 65536;
      hit = (sc >= m_cmp);
      acc = req_write && m_unl && (a != A_KEY);
      np = ((acc && a == A_CFG) ? req_wdata[28] : m_pend) || hit;
      m_rst = !m_pend && np && m_rsten;
      if (acc && a == A_FEED && req_wdata == FOOD) m_cnt = 0;
      else if (acc && a == A_CNT) m_cnt = longint'(req_wdata) % (64'd1 << 31);
      else if (hit && m_zc) m_cnt = 0;
      else if (tick && (m_ena || (m_enw && core_awake))) m_cnt = m_cnt + 1;
      m_pend = np;
      if (acc && a == A_CFG) begin
        m_scale = int'(req_wdata & 32'hF); m_rsten = req_wdata[8]; m_zc = req_wdata[9];
        m_ena = req_wdata[12]; m_enw = req_wdata[13];
      end
      if (acc && a == A_CMP) m_cmp = int'(req_wdata & 32'hFFFF);
      if (req_write) m_unl = (a == A_KEY) && (req_wdata == KEYV);
    end
    #5;
    if (!done) begin
      check(irq == m_pend, "R7", irq, m_pend);
      check(wdog_rst == m_rst, "R9", wdog_rst, m_rst);
      check(rsp_rdata == exp_read(int'(req_addr)), tag_of(int'(req_addr)), rsp_rdata,
            exp_read(int'(req_addr)));
      if (wdog_rst) pulses++;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); req_write = 1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk); req_write = 0;
  endtask

  task automatic key_wr(int a, logic [31:0] d);
    wr(A_KEY, KEYV); wr(a, d);
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk); req_addr = AW'(a); #2;
    check(rsp_rdata == exp, tag, rsp_rdata, exp);
  endtask

  task automatic rd_val(int a, output logic [31:0] v);
    @(negedge clk); req_addr = AW'(a); #2; v = rsp_rdata;
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    rd_chk(A_CFG, 32'h0, "R10"); rd_chk(A_CNT, 32'h0, "R10");
    rd_chk(A_CMP, 32'h0000FFFF, "R10"); rd_chk(A_KEY, 32'h0, "R10");
    check(irq == 0, "R10", irq, 0);
    // R1 locked write ignored
    wr(A_CMP, 32'h5); rd_chk(A_CMP, 32'h0000FFFF, "R1");
    wr(A_KEY, KEYV); rd_chk(A_KEY, 32'h1, "R1");
    wr(A_CMP, 32'hABCD0005); rd_chk(A_CMP, 32'h5, "R6");
    rd_chk(A_KEY, 32'h0, "R2");
    wr(A_CMP, 32'h9); rd_chk(A_CMP, 32'h5, "R2");
    wr(A_KEY, 32'h00012345); wr(A_CMP, 32'h9); rd_chk(A_CMP, 32'h5, "R1");
    // Always-count with reset enable: match at 5
    tick_en = 1;
    key_wr(A_CFG, 32'h0000_1100);
    repeat (20) @(negedge clk);
    check(irq == 1, "R7", irq, 1);
    check(pulses == 1, "R9", pulses, 1);
    // Feed handling
    tick_en = 0;
    repeat (2) @(negedge clk);
    rd_val(A_CNT, v);
    key_wr(A_FEED, 32'h0D09F00C);
    rd_chk(A_CNT, v, "R3"); rd_chk(A_KEY, 32'h0, "R3");
    key_wr(A_FEED, FOOD); rd_chk(A_CNT, 32'h0, "R3");
    key_wr(A_CFG, 32'h0000_1100);
    @(negedge clk); check(irq == 0, "R7", irq, 0);
    // Scale: cmp 0x10, scale 4, count 0x25
    key_wr(A_CMP, 32'h10);
    key_wr(A_CFG, 32'h0000_1004);
    key_wr(A_CNT, 32'h25);
    rd_chk(A_SCL, 32'h2, "R5"); rd_chk(A_CNT, 32'h25, "R11");
    check(irq == 0, "R7", irq, 0);
    // Awake-only mode
    key_wr(A_CFG, 32'h0000_2000);
    key_wr(A_CNT, 32'h0);
    tick_en = 1; core_awake = 0;
    repeat (10) @(negedge clk);
    rd_chk(A_CNT, 32'h0, "R4");
    core_awake = 1;
    repeat (6) @(negedge clk);
    rd_val(A_CNT, v);
    check(v > 0 && v < 32'h10, "R4", v, 7);
    // Clear-on-match with cmp 3
    key_wr(A_CMP, 32'h3);
    key_wr(A_CFG, 32'h0000_1200);
    for (int i = 0; i < 20; i++) begin
      rd_val(A_CNT, v);
      check(v <= 32'h3, "R8", v, 3);
    end
    // Disabled: count frozen
    key_wr(A_CFG, 32'h0);
    rd_val(A_CNT, v);
    repeat (8) @(negedge clk);
    rd_val(A_CNT, v2);
    check(v2 == v, "R4", v2, v);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog timeout R10 actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule